// File: doc/BRIEF.md
# Memory-Side Atomic Update Unit

This block sits at the storage end of a processor-to-memory link and performs update commands next to the data, so that a read, a modification and a write-back never cross the link as separate transfers. Each command names a word address, a 3-bit operation, a 64-bit operand, an 8-bit byte enable and a transaction tag. The unit reads the old word from a small internal synchronous array, computes the updated word, stores it, and optionally queues the old word as a response carrying the same tag.

One read-modify-write path handles every command. This path covers fetch-and-update (old value returned), update-only (nothing returned), byte-masked partial writes merged inside the unit, and plain fetches. Commands to one address take effect strictly in acceptance order. A command that targets the word whose write-back is still pending is held off at the request handshake until the write-back is done. Responses leave through a valid/ready port that tolerates backpressure. A side port lets the storage be loaded directly, and it is meant for use while no command is pending.

Top module: `amu_top`

## Requirements
- R1: After reset is released, rsp_valid is 0 and req_ready is 1 while no command is pending.
- R2: Every response carries the tag of the command that produced it in rsp_id, and the old word in rsp_data.
- R3: Operation codes 0 to 5 produce old+operand (wrapping), old AND operand, old OR operand, old XOR operand, operand (swap), and the unsigned maximum of old and operand.
- R4: Byte enable bit b selects whether bits 8b+7..8b of the stored word take the computed value; bytes with a clear bit keep their old value, and an all-zero enable leaves the word unchanged.
- R5: Operation code 6 is a plain masked write: the enabled bytes take the operand, and no response is produced whatever req_ret says.
- R6: A command with req_ret = 0 updates the word but produces no response.
- R7: Commands accepted back to back to the same address each see the result of the one before. While the previous accepted command has not yet written its address, req_ready is 0 for a request to that same address.
- R8: Responses leave in acceptance order. While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_id and rsp_data hold.
- R9: With the response queue empty, a command that returns data is accepted at one clock edge, and rsp_valid is 1 in the cycle that follows the next edge.
- R10: Operation code 7 returns the old word and leaves the storage unchanged.
- R11: req_ready is 0 whenever queued responses plus the pending command would reach the queue depth (4 by default), so no response is ever dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command accepted at this edge when req_valid is 1 |
| req_addr | input | ADDR_W | Word address |
| req_op | input | 3 | Operation code |
| req_operand | input | DATA_W | Operand word |
| req_mask | input | DATA_W/8 | Byte enables |
| req_id | input | ID_W | Transaction tag |
| req_ret | input | 1 | Return the old word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed at this edge |
| rsp_id | output | ID_W | Tag of the response |
| rsp_data | output | DATA_W | Word held before the update |
| dbg_we | input | 1 | Direct storage write enable |
| dbg_addr | input | ADDR_W | Direct write address |
| dbg_wdata | input | DATA_W | Direct write data |

## Verification
The model counts clock edges. A command accepted at edge n has its write-back at edge n+1, and its response shows at the port from edge n+2 onward, provided earlier responses have drained. req_ready is predicted combinationally in the same cycle from the pending command and the number of responses already visible. The bench drives inputs and samples outputs at the falling edge. It compares rsp_valid, rsp_id, rsp_data and req_ready against the model in every cycle, so latency, ordering, stalls and backpressure are all checked at the cycle where they are due.

// File: rtl/amu_pkg.sv
package amu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_AND   = 3'd1,
        OP_OR    = 3'd2,
        OP_XOR   = 3'd3,
        OP_SWAP  = 3'd4,
        OP_MAXU  = 3'd5,
        OP_WRITE = 3'd6,
        OP_FETCH = 3'd7
    } amu_op_e;

endpackage

// File: rtl/amu_alu.sv
module amu_alu
    import amu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amu_op_e                 op,
    input  logic [DATA_W-1:0]       old_word,
    input  logic [DATA_W-1:0]       operand,
    input  logic [DATA_W/8-1:0]     byte_en,
    output logic [DATA_W-1:0]       new_word
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] raw;

    // full-width result before byte merging
    always_comb begin
        case (op)
            OP_ADD:   raw = old_word + operand;
            OP_AND:   raw = old_word & operand;
            OP_OR:    raw = old_word | operand;
            OP_XOR:   raw = old_word ^ operand;
            OP_SWAP:  raw = operand;
            OP_MAXU:  raw = (operand > old_word) ? operand : old_word;
            OP_WRITE: raw = operand;
            default:  raw = old_word;
        endcase
    end

    // per-byte merge: disabled bytes keep the stored value
    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign new_word[8*b +: 8] = byte_en[b] ? raw[8*b +: 8] : old_word[8*b +: 8];
    end

endmodule

// File: rtl/amu_store.sv
module amu_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                ld_en,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [DATA_W-1:0]   ld_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] words [WORDS];
    logic [DATA_W-1:0] rd_q;

    // contents are not reset; the direct load port comes last and wins a tie
    always_ff @(posedge clk) begin
        if (wr_en) words[wr_addr] <= wr_data;
        if (ld_en) words[ld_addr] <= ld_data;
        if (rd_en) rd_q <= words[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/amu_rsp_fifo.sv
module amu_rsp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 68
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [W-1:0]                    push_data,
    input  logic                            out_ready,
    output logic                            out_valid,
    output logic [W-1:0]                    out_data,
    output logic [$clog2(DEPTH+1)-1:0]      count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [W-1:0] slots [DEPTH];
    logic pop;

    assign pop = out_valid && out_ready;

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        if (pop)  st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) slots[st_q.wr] <= push_data;
    end

    assign out_valid = (st_q.cnt != '0);
    assign out_data  = slots[st_q.rd];
    assign count     = st_q.cnt;

endmodule

// File: rtl/amu_top.sv
module amu_top
    import amu_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 64,
    parameter int ID_W      = 4,
    parameter int RSP_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [2:0]              req_op,
    input  logic [DATA_W-1:0]       req_operand,
    input  logic [DATA_W/8-1:0]     req_mask,
    input  logic [ID_W-1:0]         req_id,
    input  logic                    req_ret,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [ID_W-1:0]         rsp_id,
    output logic [DATA_W-1:0]       rsp_data,
    input  logic                    dbg_we,
    input  logic [ADDR_W-1:0]       dbg_addr,
    input  logic [DATA_W-1:0]       dbg_wdata
);
    localparam int MASK_W = DATA_W / 8;
    localparam int RSP_W  = ID_W + DATA_W;
    localparam int CNT_W  = $clog2(RSP_DEPTH + 1);
    localparam logic [CNT_W:0] OCC_LIMIT = (CNT_W + 1)'(RSP_DEPTH);

    // command that was accepted last edge and writes back at the next one
    typedef struct packed {
        logic               valid;
        logic               ret;
        amu_op_e            op;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  operand;
        logic [MASK_W-1:0]  mask;
        logic [ID_W-1:0]    id;
    } wb_st_t;

    wb_st_t st_q, st_d;

    logic               accept;
    logic               addr_busy;
    logic               room;
    logic [CNT_W:0]     occ;
    logic [CNT_W-1:0]   rsp_cnt;
    logic [DATA_W-1:0]  old_word;
    logic [DATA_W-1:0]  new_word;
    logic               rsp_push;
    logic [RSP_W-1:0]   rsp_word;
    logic               wb_valid;
    logic [ADDR_W-1:0]  wb_addr;

    assign wb_valid = st_q.valid;
    assign wb_addr  = st_q.addr;

    // same-address hazard and response space
    assign addr_busy = wb_valid && (wb_addr == req_addr);
    assign occ       = {1'b0, rsp_cnt} + {{CNT_W{1'b0}}, wb_valid};
    assign room      = (occ < OCC_LIMIT);
    assign req_ready = !addr_busy && room;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d       = st_q;
        st_d.valid = accept;
        if (accept) begin
            st_d.ret     = req_ret;
            st_d.op      = amu_op_e'(req_op);
            st_d.addr    = req_addr;
            st_d.operand = req_operand;
            st_d.mask    = req_mask;
            st_d.id      = req_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    amu_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rd_en   (accept),
        .rd_addr (req_addr),
        .rd_data (old_word),
        .wr_en   (st_q.valid),
        .wr_addr (st_q.addr),
        .wr_data (new_word),
        .ld_en   (dbg_we),
        .ld_addr (dbg_addr),
        .ld_data (dbg_wdata)
    );

    amu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op       (st_q.op),
        .old_word (old_word),
        .operand  (st_q.operand),
        .byte_en  (st_q.mask),
        .new_word (new_word)
    );

    assign rsp_push = st_q.valid && st_q.ret && (st_q.op != OP_WRITE);

    amu_rsp_fifo #(
        .DEPTH (RSP_DEPTH),
        .W     (RSP_W)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rsp_push),
        .push_data ({st_q.id, old_word}),
        .out_ready (rsp_ready),
        .out_valid (rsp_valid),
        .out_data  (rsp_word),
        .count     (rsp_cnt)
    );

    assign rsp_id   = rsp_word[RSP_W-1 -: ID_W];
    assign rsp_data = rsp_word[DATA_W-1:0];

endmodule

// File: rtl/amu_chk.sv
module amu_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 64,
    parameter int ID_W   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [2:0]           req_op,
    input logic                 req_ret,
    input logic                 rsp_valid,
    input logic                 rsp_ready,
    input logic [ID_W-1:0]      rsp_id,
    input logic [DATA_W-1:0]    rsp_data,
    input logic                 wb_valid,
    input logic [ADDR_W-1:0]    wb_addr
);

    // R1: reset empties the response queue
    p_rst_empty_r1: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

    // R7: an accepted command writes its own address at the next edge
    p_wb_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (wb_valid && wb_addr == $past(req_addr)));

    // R8: a stalled response holds its contents
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_data)));

    // R8: a response leaves only through a handshake
    p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_valid) |-> $past(rsp_ready));

    // R9: returning command into an empty queue responds two edges later
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_ret && req_op != 3'd6 && !rsp_valid) |-> ##2 rsp_valid);

endmodule

bind amu_top amu_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_op    (req_op),
    .req_ret   (req_ret),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_id    (rsp_id),
    .rsp_data  (rsp_data),
    .wb_valid  (wb_valid),
    .wb_addr   (wb_addr)
);

// File: tb/amu_top_tb_top.sv
`timescale 1ns/1ps
module amu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_addr = '0;
    logic [2:0]  req_op = '0;
    logic [63:0] req_operand = '0;
    logic [7:0]  req_mask = '0;
    logic [3:0]  req_id = '0;
    logic        req_ret = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [3:0]  rsp_id;
    logic [63:0] rsp_data;
    logic        dbg_we = 1'b0;
    logic [3:0]  dbg_addr = '0;
    logic [63:0] dbg_wdata = '0;

    always #2.5 clk = ~clk;

    amu_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_op      (req_op),
        .req_operand (req_operand),
        .req_mask    (req_mask),
        .req_id      (req_id),
        .req_ret     (req_ret),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_id      (rsp_id),
        .rsp_data    (rsp_data),
        .dbg_we      (dbg_we),
        .dbg_addr    (dbg_addr),
        .dbg_wdata   (dbg_wdata)
    );

    // ---------------- reference model ----------------
    typedef struct {
        logic [3:0]  id;
        logic [63:0] data;
        int          due;
    } exp_t;

    exp_t        q[$];
    logic [63:0] mm [16];
    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          bp_mode = 0;
    int          acc_cyc = -10;
    logic [3:0]  acc_addr = '0;
    logic [3:0]  next_id = '0;
    bit          pop_pending = 0;
    string       cur_tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] f_new(logic [2:0] op, logic [63:0] o, logic [63:0] d, logic [7:0] m);
        logic [63:0] r;
        logic [63:0] res;
        case (op)
            3'd0: r = o + d;
            3'd1: r = o & d;
            3'd2: r = o | d;
            3'd3: r = o ^ d;
            3'd4: r = d;
            3'd5: r = (d > o) ? d : o;
            3'd6: r = d;
            default: r = o;
        endcase
        for (int b = 0; b < 8; b++)
            res[b*8 +: 8] = m[b] ? r[b*8 +: 8] : o[b*8 +: 8];
        return res;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // one cycle: at the falling edge set rsp_ready, compare outputs, retire
    task automatic tick();
        bit exp_v;
        @(negedge clk);
        rsp_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? 1'b0 : 1'($urandom_range(0, 1));
        exp_v = (q.size() > 0) && (q[0].due <= cyc);
        check(rsp_valid == exp_v, {"R9 ", cur_tag}, "rsp_valid", {63'b0, rsp_valid}, {63'b0, exp_v});
        pop_pending = 0;
        if (exp_v && rsp_valid) begin
            check(rsp_id == q[0].id, "R2", "rsp_id", {60'b0, rsp_id}, {60'b0, q[0].id});
            check(rsp_data === q[0].data, cur_tag, "rsp_data", rsp_data, q[0].data);
            if (rsp_ready) begin
                pop_pending = 1;
                void'(q.pop_front());
            end
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    function automatic bit model_ready(logic [3:0] a);
        int  vis;
        bit  wb;
        vis = pop_pending ? 1 : 0;
        foreach (q[i]) if (q[i].due <= cyc) vis++;
        wb = (acc_cyc == cyc - 1);
        return !(wb && acc_addr == a) && ((vis + (wb ? 1 : 0)) < 4);
    endfunction

    task automatic issue(input logic [3:0] a, input logic [2:0] op, input logic [63:0] opd,
                         input logic [7:0] m, input bit ret, input int unstall_after);
        bit done = 0;
        int waited = 0;
        bit mr;
        logic [63:0] old;
        req_addr = a; req_op = op; req_operand = opd; req_mask = m;
        req_ret = ret; req_id = next_id; req_valid = 1'b1;
        while (!done) begin
            #1;
            mr = model_ready(a);
            check(req_ready == mr, (op == 3'd0 && cur_tag == "R7") ? "R7" : {"R11 ", cur_tag},
                  "req_ready", {63'b0, req_ready}, {63'b0, mr});
            if (req_ready) begin
                done = 1;
                old = mm[a];
                mm[a] = f_new(op, old, opd, m);
                if (ret && op != 3'd6) q.push_back('{id: next_id, data: old, due: cyc + 2});
                acc_cyc = cyc;
                acc_addr = a;
                next_id = next_id + 4'd1;
            end
            tick();
            waited++;
            if (unstall_after > 0 && waited >= unstall_after) bp_mode = 0;
        end
        req_valid = 1'b0;
    endtask

    task automatic preload(input logic [3:0] a, input logic [63:0] v);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = v;
        mm[a] = v;
        tick();
        dbg_we = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        cur_tag = "R1";
        #1;
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", {63'b0, req_ready}, 64'd1);
        idle(1);

        for (int a = 0; a < 16; a++)
            preload(4'(a), 64'hF0E0_D0C0_B0A0_9080 + 64'(a) * 64'h0101_0101_0101_0101);
        idle(2);

        // R3: each operation, full mask, with return
        cur_tag = "R3";
        issue(4'd0, 3'd0, 64'h0000_0000_0000_1234, 8'hFF, 1, 0);
        idle(3);
        issue(4'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1, 0);
        issue(4'd2, 3'd1, 64'h0F0F_0F0F_00FF_FF00, 8'hFF, 1, 0);
        issue(4'd3, 3'd2, 64'h0000_1111_2222_0000, 8'hFF, 1, 0);
        issue(4'd4, 3'd3, 64'hFFFF_0000_FFFF_0000, 8'hFF, 1, 0);
        issue(4'd5, 3'd4, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF, 1, 0);
        issue(4'd6, 3'd5, 64'hFFFF_0000_0000_0000, 8'hFF, 1, 0);
        issue(4'd7, 3'd5, 64'h0000_0000_0000_0001, 8'hFF, 1, 0);
        idle(4);

        // R10: fetch leaves the word unchanged
        cur_tag = "R10";
        for (int a = 0; a < 8; a++) issue(4'(a), 3'd7, 64'h5555_5555_5555_5555, 8'hFF, 1, 0);
        issue(4'd5, 3'd7, 64'd0, 8'h00, 1, 0);
        idle(4);

        // R4: partial byte enables
        cur_tag = "R4";
        issue(4'd8,  3'd0, 64'h0101_0101_0101_0101, 8'h0F, 1, 0);
        issue(4'd9,  3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'h81, 1, 0);
        issue(4'd10, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 1, 0);
        issue(4'd11, 3'd4, 64'h1122_3344_5566_7788, 8'hA5, 1, 0);
        for (int a = 8; a < 12; a++) issue(4'(a), 3'd7, 64'd0, 8'hFF, 1, 0);
        idle(4);

        // R5: plain masked write never responds
        cur_tag = "R5";
        issue(4'd12, 3'd6, 64'hABCD_EF01_2345_6789, 8'h3C, 1, 0);
        issue(4'd13, 3'd6, 64'h0000_0000_0000_0000, 8'hFF, 0, 0);
        idle(3);
        issue(4'd12, 3'd7, 64'd0, 8'hFF, 1, 0);
        issue(4'd13, 3'd7, 64'd0, 8'hFF, 1, 0);
        idle(4);

        // R6: update without return
        cur_tag = "R6";
        issue(4'd14, 3'd0, 64'd100, 8'hFF, 0, 0);
        issue(4'd15, 3'd3, 64'hFF00_FF00_FF00_FF00, 8'hFF, 0, 0);
        idle(3);
        issue(4'd14, 3'd7, 64'd0, 8'hFF, 1, 0);
        issue(4'd15, 3'd7, 64'd0, 8'hFF, 1, 0);
        idle(4);

        // R7: back-to-back commands to one address
        cur_tag = "R7";
        for (int i = 0; i < 5; i++) issue(4'd3, 3'd0, 64'd1, 8'hFF, 1, 0);
        for (int i = 0; i < 4; i++) issue(4'(3 + (i % 2)), 3'd0, 64'd7, 8'hFF, 1, 0);
        idle(4);

        // R8: random traffic under random backpressure
        cur_tag = "R8";
        bp_mode = 2;
        for (int i = 0; i < 40; i++)
            issue(4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)),
                  {$urandom, $urandom}, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), 0);
        bp_mode = 0;
        idle(8);

        // R11: queue full stalls the request port
        cur_tag = "R11";
        bp_mode = 1;
        for (int a = 8; a < 12; a++) issue(4'(a), 3'd0, 64'd2, 8'hFF, 1, 0);
        issue(4'd12, 3'd0, 64'd2, 8'hFF, 1, 6);
        idle(8);

        // final readback of every word
        cur_tag = "R10";
        for (int a = 0; a < 16; a++) issue(4'(a), 3'd7, 64'd0, 8'hFF, 1, 0);
        idle(8);
        check(q.size() == 0, "R8", "responses outstanding", 64'(q.size()), 64'd0);

        finish_run();
    end

endmodule